// File: doc/BRIEF.md
# Two-Channel Split-Count Pulse Generator

This peripheral produces two independent pulse-width-modulated outputs. It is driven by a small 32-bit register bus. Each channel has its own count register. The upper half of that register sets how many ticks the output stays high, and the lower half sets how many ticks it then stays low. The pattern repeats, so the period is the sum of the two counts.

A tick comes from a per-channel clock divider whose 7-bit setting N divides the system clock by N+1. A shared control register holds both divider settings, a clock-enable bit per channel and an output-enable bit per channel. A channel runs only while both of its enable bits are set.

Count and divider values written while a channel runs are held back until the current period ends, so software can retune a running output without producing a short or torn period. A stopped channel drives low. When it starts again it always begins with the high phase.

Top module: `dpwm_top`

## Requirements
- R1: Registers sit at byte offsets 0x0 (channel A counts), 0x4 (channel B counts) and 0x8 (control). The bus decodes only address bits 3:2. Offset 0xC reads zero, and writes to it change nothing.
- R2: Read data is registered and appears one clock after the address is presented. Every register reads back the value last written. Control bits other than 0, 1 and 8–23 read as zero, so writing all ones to control reads back 0x00FFFF03.
- R3: In a count register, bits 31:16 give the high-phase ticks and bits 15:0 give the low-phase ticks. A running output is high for the high count of ticks, then low for the low count, and repeats.
- R4: Channel A's divider setting is in control bits 14:8 and channel B's is in bits 22:16. A setting N makes one tick every N+1 clocks, which covers ratios 1 to 128.
- R5: Channel A runs only when control bit 15 (clock enable) and bit 0 (output enable) are both 1. Channel B needs bit 23 and bit 1. A channel that does not run drives its output 0.
- R6: Take the clock edge at which a write makes a channel run as edge 0. The output value after edge 2+m is high exactly when floor(m/(N+1)) mod (high+low) is less than high. The first tick therefore falls in the high phase.
- R7: A high count of 0 gives a constant low output. A low count of 0 with a nonzero high count gives a constant high output.
- R8: Counts and divider settings written while a channel runs take effect only at the start of the next period, and the current period finishes with the old values.
- R9: Clearing only the output-enable bit stops the channel. Its output is 0 after the first clock edge that follows the write.
- R10: A synchronous active-high reset clears all registers, read data and both outputs.
- R11: The two channels run independently, each with its own counts and divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the divider input |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Byte address; bits 3:2 select the register |
| we | input | 1 | Write strobe for the addressed register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pwm_a_o | output | 1 | Channel A output |
| pwm_b_o | output | 1 | Channel B output |

## Verification
The hardest case to reach is a write that lands in the middle of a running period. The new values must stay held back and then switch in at exactly the next period boundary. The bench starts a channel with a short known period, counts a fixed number of clocks so that the rewrite lands at a known tick inside the second period, and then checks every cycle against a piecewise expectation that switches at the computed boundary. Random runs with a fixed seed mix count and divider values, including zero counts, and place the active channel on either side. Directed runs cover the largest divider and a stop issued mid-period.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int NCH      = 2;   // channels
  localparam int DATA_W   = 32;  // bus width
  localparam int ADDR_W   = 4;   // byte address width
  localparam int CNT_W    = 16;  // per-phase tick count
  localparam int DIV_W    = 7;   // divider setting width
  localparam int DIV_LSB  = 8;   // lsb of channel 0 divider field
  localparam int DIV_STEP = 8;   // field stride between channels
  localparam int CKEN_OFS = 7;   // clock enable sits above divider field

  typedef enum logic [1:0] {
    SEL_CNT_A = 2'd0,
    SEL_CNT_B = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dpwm_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         we,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  output logic [NCH-1:0][CNT_W-1:0]    hi_cnt,
  output logic [NCH-1:0][CNT_W-1:0]    lo_cnt,
  output logic [NCH-1:0][DIV_W-1:0]    div_set,
  output logic [NCH-1:0]               act
);
  reg_sel_e sel;
  logic [NCH-1:0][DATA_W-1:0] cnt_q;
  logic [NCH-1:0][DIV_W-1:0]  div_q;
  logic [NCH-1:0]             cken_q;
  logic [NCH-1:0]             oen_q;
  logic [DATA_W-1:0]          ctrl_view;

  assign sel = reg_sel_e'(addr[3:2]);

  always_comb begin
    ctrl_view = '0;
    for (int i = 0; i < NCH; i++) begin
      ctrl_view[i]                                   = oen_q[i];
      ctrl_view[DIV_LSB + DIV_STEP*i +: DIV_W]       = div_q[i];
      ctrl_view[DIV_LSB + DIV_STEP*i + CKEN_OFS]     = cken_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      div_q  <= '0;
      cken_q <= '0;
      oen_q  <= '0;
    end else if (we) begin
      case (sel)
        SEL_CNT_A: cnt_q[0] <= wdata;
        SEL_CNT_B: cnt_q[1] <= wdata;
        SEL_CTRL: begin
          for (int i = 0; i < NCH; i++) begin
            oen_q[i]  <= wdata[i];
            div_q[i]  <= wdata[DIV_LSB + DIV_STEP*i +: DIV_W];
            cken_q[i] <= wdata[DIV_LSB + DIV_STEP*i + CKEN_OFS];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (sel)
        SEL_CNT_A: rdata <= cnt_q[0];
        SEL_CNT_B: rdata <= cnt_q[1];
        SEL_CTRL:  rdata <= ctrl_view;
        default:   rdata <= '0;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_cfg
      assign hi_cnt[g]  = cnt_q[g][DATA_W-1 -: CNT_W];
      assign lo_cnt[g]  = cnt_q[g][CNT_W-1:0];
      assign div_set[g] = div_q[g];
      assign act[g]     = cken_q[g] & oen_q[g];
    end
  endgenerate
endmodule

// File: rtl/dpwm_chan.sv
module dpwm_chan
  import dpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [CNT_W-1:0] hi_in,
  input  logic [CNT_W-1:0] lo_in,
  input  logic [DIV_W-1:0] div_in,
  output logic             pwm_o
);
  localparam int TOT_W = CNT_W + 1;

  logic             run_q;
  logic [DIV_W-1:0] pre_q;
  logic [TOT_W-1:0] pos_q;
  logic [CNT_W-1:0] sh_hi, sh_lo;
  logic [DIV_W-1:0] sh_div;
  logic [TOT_W-1:0] total;
  logic             tick, wrap;

  assign total = TOT_W'(sh_hi) + TOT_W'(sh_lo);
  assign tick  = (pre_q == sh_div);
  assign wrap  = (total == '0) || (pos_q == total - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      pre_q  <= '0;
      pos_q  <= '0;
      sh_hi  <= '0;
      sh_lo  <= '0;
      sh_div <= '0;
      pwm_o  <= 1'b0;
    end else begin
      run_q <= active;
      pwm_o <= active && run_q && (pos_q < TOT_W'(sh_hi));
      if (!active || !run_q) begin
        pre_q  <= '0;
        pos_q  <= '0;
        sh_hi  <= hi_in;
        sh_lo  <= lo_in;
        sh_div <= div_in;
      end else if (tick) begin
        pre_q <= '0;
        if (wrap) begin
          pos_q  <= '0;
          sh_hi  <= hi_in;
          sh_lo  <= lo_in;
          sh_div <= div_in;
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dpwm_top.sv
module dpwm_top
  import dpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pwm_a_o,
  output logic              pwm_b_o
);
  logic [NCH-1:0][CNT_W-1:0] hi_cnt, lo_cnt;
  logic [NCH-1:0][DIV_W-1:0] div_set;
  logic [NCH-1:0]            act;
  logic [NCH-1:0]            pwm_vec;

  dpwm_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .we      (we),
    .wdata   (wdata),
    .rdata   (rdata),
    .hi_cnt  (hi_cnt),
    .lo_cnt  (lo_cnt),
    .div_set (div_set),
    .act     (act)
  );

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      dpwm_chan u_chan (
        .clk    (clk),
        .rst    (rst),
        .active (act[g]),
        .hi_in  (hi_cnt[g]),
        .lo_in  (lo_cnt[g]),
        .div_in (div_set[g]),
        .pwm_o  (pwm_vec[g])
      );
    end
  endgenerate

  assign pwm_a_o = pwm_vec[0];
  assign pwm_b_o = pwm_vec[1];
endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker
  import dpwm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic [NCH-1:0]    act,
  input logic              pwm_a_o,
  input logic              pwm_b_o
);
  a_r5_idle_a: assert property (@(posedge clk) disable iff (rst)
    !act[0] |=> !pwm_a_o);

  a_r5_idle_b: assert property (@(posedge clk) disable iff (rst)
    !act[1] |=> !pwm_b_o);

  a_r2_ctrl_mask: assert property (@(posedge clk) disable iff (rst)
    (addr[3:2] == 2'd2) |=> ((rdata & 32'hFF00_00FC) == 32'd0));

  a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (addr[3:2] == 2'd3) |=> (rdata == 32'd0));

  a_r10_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!pwm_a_o && !pwm_b_o && rdata == 32'd0));
endmodule

bind dpwm_top dpwm_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .rdata   (rdata),
  .act     (act),
  .pwm_a_o (pwm_a_o),
  .pwm_b_o (pwm_b_o)
);

// File: tb/tb_dpwm_top.sv
module tb_dpwm_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm_a_o, pwm_b_o;

  int checks = 0;
  int errors = 0;

  dpwm_top dut (
    .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata),
    .rdata(rdata), .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o)
  );

  always #4 clk = ~clk;

  function automatic bit model(int m, int d, int hi, int lo);
    int tot = hi + lo;
    if (tot == 0) return 1'b0;
    return ((m / d) % tot) < hi;
  endfunction

  function automatic logic [31:0] ctrl_word(int da, bit ca, bit ea, int db, bit cb, bit eb);
    logic [31:0] w = '0;
    w[0] = ea; w[1] = eb;
    w[14:8] = da[6:0]; w[15] = ca;
    w[22:16] = db[6:0]; w[23] = cb;
    return w;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    @(posedge clk);
    #2 d = rdata;
  endtask

  // Starts channels with one control write and checks n cycles of both outputs.
  task automatic run_check(string req, int ha, int la, int da, bit ca, bit ea,
                           int hb, int lb, int db, bit cb, bit eb, int n);
    int bad_a = 0, bad_b = 0;
    bit ra = ca && ea, rb = cb && eb;
    bit ea_x = 0, eb_x = 0, aa = 0, ab = 0;
    wr(4'h8, 32'd0);
    wr(4'h0, {ha[15:0], la[15:0]});
    wr(4'h4, {hb[15:0], lb[15:0]});
    wr(4'h8, ctrl_word(da, ca, ea, db, cb, eb));
    @(posedge clk);
    for (int m = 0; m < n; m++) begin
      bit xa, xb;
      @(posedge clk);
      #2;
      xa = ra ? model(m, da + 1, ha, la) : 1'b0;
      xb = rb ? model(m, db + 1, hb, lb) : 1'b0;
      if (pwm_a_o !== xa && bad_a == 0) begin aa = pwm_a_o; ea_x = xa; end
      if (pwm_b_o !== xb && bad_b == 0) begin ab = pwm_b_o; eb_x = xb; end
      if (pwm_a_o !== xa) bad_a++;
      if (pwm_b_o !== xb) bad_b++;
    end
    check(bad_a == 0, {req, " chA"}, aa, ea_x);
    check(bad_b == 0, {req, " chB"}, ab, eb_x);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int bad;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R10: reset state
    rd(4'h0, v); check(v == 0, "R10 cntA", v, 0);
    rd(4'h4, v); check(v == 0, "R10 cntB", v, 0);
    rd(4'h8, v); check(v == 0, "R10 ctrl", v, 0);
    check(pwm_a_o == 0 && pwm_b_o == 0, "R10 outputs", {pwm_a_o, pwm_b_o}, 0);

    // R1 / R2: map and readback
    wr(4'h0, 32'h1234_5678); wr(4'h4, 32'hCAFE_0001);
    rd(4'h0, v); check(v == 32'h1234_5678, "R1 R2 cntA", v, 32'h1234_5678);
    rd(4'h4, v); check(v == 32'hCAFE_0001, "R1 R2 cntB", v, 32'hCAFE_0001);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, v); check(v == 32'h00FF_FF03, "R2 ctrl mask", v, 32'h00FF_FF03);
    wr(4'h8, 32'd0);
    wr(4'hC, 32'hDEAD_BEEF);
    rd(4'hC, v); check(v == 0, "R1 unmapped", v, 0);
    rd(4'h0, v); check(v == 32'h1234_5678, "R1 unmapped no side effect", v, 32'h1234_5678);

    // R3 / R6 basic, R4 divider
    run_check("R3 R6", 3, 2, 0, 1, 1, 0, 0, 0, 0, 0, 30);
    run_check("R4 div3", 2, 3, 3, 1, 1, 0, 0, 0, 0, 0, 80);
    run_check("R4 div127", 1, 1, 127, 1, 1, 0, 0, 0, 0, 0, 600);
    // R5: each enable alone
    run_check("R5 oen only", 2, 2, 0, 0, 1, 2, 2, 0, 0, 1, 20);
    run_check("R5 cken only", 2, 2, 0, 1, 0, 2, 2, 0, 1, 0, 20);
    // R7: degenerate counts
    run_check("R7 hi zero", 0, 5, 0, 1, 1, 0, 0, 0, 1, 1, 30);
    run_check("R7 lo zero", 4, 0, 1, 1, 1, 7, 0, 0, 1, 1, 30);
    // R11: both channels at once
    run_check("R11 both", 1, 3, 0, 1, 1, 2, 1, 1, 1, 1, 60);

    // Random mix
    for (int k = 0; k < 20; k++) begin
      int h = $urandom_range(0, 6), l = $urandom_range(0, 6), d = $urandom_range(0, 3);
      bit sideb = $urandom_range(0, 1);
      if (sideb)
        run_check("R3 R4 R6 rand", 0, 0, 0, 1, 0, h, l, d, 1, 1, 60);
      else
        run_check("R3 R4 R6 rand", h, l, d, 1, 1, 0, 0, 0, 1, 0, 60);
    end

    // R8: rewrite mid-period, takes effect at boundary m=10
    wr(4'h8, 32'd0);
    wr(4'h0, {16'd3, 16'd2});
    wr(4'h8, ctrl_word(0, 1, 1, 0, 0, 0));
    @(posedge clk);
    bad = 0;
    for (int m = 0; m < 7; m++) begin
      @(posedge clk); #2;
      if (pwm_a_o !== model(m, 1, 3, 2)) bad++;
    end
    wr(4'h0, {16'd1, 16'd1});   // write edge is m=7
    for (int m = 8; m < 40; m++) begin
      bit x;
      @(posedge clk); #2;
      x = (m < 10) ? model(m, 1, 3, 2) : model(m - 10, 1, 1, 1);
      if (pwm_a_o !== x) bad++;
    end
    check(bad == 0, "R8 shadow boundary", bad, 0);

    // R9: clear output enable only while running
    wr(4'h0, {16'd8, 16'd8});
    wr(4'h8, ctrl_word(0, 1, 1, 0, 0, 0));
    repeat (4) @(posedge clk);
    #2 check(pwm_a_o == 1, "R9 running high", pwm_a_o, 1);
    wr(4'h8, ctrl_word(0, 1, 0, 0, 0, 0));
    @(posedge clk); #2;
    check(pwm_a_o == 0, "R9 stop next edge", pwm_a_o, 0);
    bad = 0;
    for (int m = 0; m < 20; m++) begin
      @(posedge clk); #2;
      if (pwm_a_o !== 0) bad++;
    end
    check(bad == 0, "R9 stays low", bad, 0);
    rd(4'h8, v); check(v == 32'h0000_8000, "R9 R2 ctrl after stop", v, 32'h0000_8000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule